// File: doc/BRIEF.md
# SAR ADC Track-Convert Sequencer

This block is the digital controller for a 10-bit successive-approximation converter. It works out when the sample-and-hold tracks the input and when the comparator and DAC resolve the stored sample. It also signals when a result is ready. The sequencer runs on the SAR clock, with one `clk` edge per SAR clock. It picks one of four start sources with a 2-bit select field. It then runs a conversion of 11 SAR clocks that resolves one bit per clock, most significant bit first.

Two tracking policies are supported. In continuous mode the input is tracked whenever no conversion is running. In low-power mode the sample-and-hold sits in a low-power state between conversions, and tracking depends on the trigger:
- After an internal trigger, a fixed three-clock tracking window comes before the conversion.
- With the external pin, tracking follows the synchronised pin while it is low, and the conversion starts on its rising edge.

A sleep input turns tracking off in every mode. The analog comparator is modelled as one decision bit. The block drives the trial code on `trialCode`, and the comparator returns `cmpBit`.

Top module: `sar_seq_top`

## Requirements
- R1: In every cycle out of reset, exactly one of `trackPhase`, `convPhase` and `lowPowerIdle` is high.
- R2: With `lowPowerMode`=0 and `sleepReq`=0, `trackPhase` is high in every idle cycle. An internal start goes straight to conversion: `busy` is high for exactly 11 cycles, and `trackPhase` is never high during those cycles.
- R3: With `lowPowerMode`=1 and an internal trigger, the idle cycles show `lowPowerIdle`. A start gives 3 cycles of `trackPhase` and then 11 cycles of `convPhase`, with `busy` high for all 14.
- R4: A conversion phase lasts exactly 11 consecutive clocks. Clocks 1 to 10 test result bits 9 down to 0, one per clock. In each of those clocks `trialCode` equals the bits decided so far with the bit under test set to 1. A `cmpBit` of 1 keeps that bit and a 0 clears it. Clock 11 latches the result.
- R5: `startSel` picks the start source: 00 is `swStart`, 01 is `tmrAOvf`, 11 is `tmrBOvf`, and 10 is a rising edge on `extConvPin`. Pulses on the sources that are not selected start nothing.
- R6: While `sleepReq` is 1, `trackPhase` is 0 in every mode.
- R7: `busy` rises in the cycle after the start is sampled and stays high through the last conversion clock. It falls in the same cycle as a one-cycle `donePulse`.
- R8: `result` changes only in the cycle where `donePulse` is high. It then holds the 10-bit code that the bit decisions produced.
- R9: Start events that arrive while `busy` is high are ignored. They neither lengthen nor restart the sequence.
- R10: `extConvPin` passes through a two-flop synchroniser. A rising edge applied just after a clock edge makes `busy` high after the third following edge. In low-power mode with source 10, `trackPhase` follows the synchronised pin being low while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | SAR clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| startSel | input | 2 | Start source select |
| lowPowerMode | input | 1 | 1 selects low-power tracking |
| sleepReq | input | 1 | Standby/sleep; forces tracking off |
| swStart | input | 1 | Software start pulse |
| tmrAOvf | input | 1 | First timer overflow pulse |
| tmrBOvf | input | 1 | Second timer overflow pulse |
| extConvPin | input | 1 | Asynchronous external convert-start pin |
| cmpBit | input | 1 | Comparator decision for the current trial code |
| trialCode | output | 10 | Code presented to the DAC |
| trackPhase | output | 1 | Sample-and-hold tracking |
| convPhase | output | 1 | Conversion in progress |
| lowPowerIdle | output | 1 | Sample-and-hold in low-power state |
| busy | output | 1 | Sequence active |
| donePulse | output | 1 | One-cycle end-of-conversion strobe |
| result | output | 10 | Last converted code |

## Verification
The hardest case to reach is an external-pin conversion in low-power mode. Tracking there is set by the synchronised pin level, not by an internal window, and the start lags the pin by the synchroniser depth. The bench holds the pin low long enough to see tracking through the synchroniser. It then raises the pin just after a clock edge and checks that `busy` is still low after two edges and high after the third. Bit resolution is exercised by a comparator model in the bench that compares `trialCode` against a target value. A correct SAR sequence must then return exactly that target.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
  localparam int IDX_W = 5;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_TRACK = 2'd1,
    ST_CONV  = 2'd2
  } seqState_t;

  typedef struct packed {
    logic             clearWork;
    logic             decideBit;
    logic             latchResult;
    logic [IDX_W-1:0] bitIdx;
  } sarStrobe_t;

  localparam logic [1:0] SEL_SW   = 2'b00;
  localparam logic [1:0] SEL_TMRA = 2'b01;
  localparam logic [1:0] SEL_EXT  = 2'b10;
  localparam logic [1:0] SEL_TMRB = 2'b11;
endpackage

// File: rtl/sar_seq_dp.sv
module sar_seq_dp
  import sar_seq_pkg::*;
#(
  parameter int RES_BITS = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                extPinRaw,
  input  logic                cmpBit,
  input  sarStrobe_t          strobe,
  output logic                extLevel,
  output logic                extRise,
  output logic [RES_BITS-1:0] trialCode,
  output logic [RES_BITS-1:0] result
);
  logic [SYNC_STAGES:0]  syncChain;
  logic [RES_BITS-1:0]   work;
  logic [RES_BITS-1:0]   testMask;

  // synchroniser plus one extra stage for edge detection
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) syncChain <= '0;
    else        syncChain <= {syncChain[SYNC_STAGES-1:0], extPinRaw};
  end

  assign extLevel = syncChain[SYNC_STAGES-1];
  assign extRise  = syncChain[SYNC_STAGES-1] & ~syncChain[SYNC_STAGES];

  for (genvar i = 0; i < RES_BITS; i++) begin : g_mask
    assign testMask[i] = strobe.decideBit && (strobe.bitIdx == IDX_W'(i));
  end

  assign trialCode = work | testMask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      work <= '0;
    end else if (strobe.clearWork) begin
      work <= '0;
    end else if (strobe.decideBit) begin
      work <= (work & ~testMask) | (testMask & {RES_BITS{cmpBit}});
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  result <= '0;
    else if (strobe.latchResult) result <= work;
  end
endmodule

// File: rtl/sar_seq_ctrl.sv
module sar_seq_ctrl
  import sar_seq_pkg::*;
#(
  parameter int RES_BITS = 10,
  parameter int LP_TRACK_CLKS = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] startSel,
  input  logic       lowPowerMode,
  input  logic       sleepReq,
  input  logic       swStart,
  input  logic       tmrAOvf,
  input  logic       tmrBOvf,
  input  logic       extRise,
  input  logic       extLevel,
  output sarStrobe_t strobe,
  output logic       busy,
  output logic       trackPhase,
  output logic       convPhase,
  output logic       lowPowerIdle,
  output logic       donePulse
);
  localparam int CONV_CLKS = RES_BITS + 1;
  localparam int CNT_W = $clog2(CONV_CLKS + LP_TRACK_CLKS + 1);
  localparam logic [CNT_W-1:0] LAST_CONV  = CNT_W'(CONV_CLKS - 1);
  localparam logic [CNT_W-1:0] LAST_TRACK = CNT_W'(LP_TRACK_CLKS - 1);
  localparam logic [CNT_W-1:0] NUM_BITS   = CNT_W'(RES_BITS);

  seqState_t        state;
  logic [CNT_W-1:0] cnt;
  logic             startEvt;
  logic             extMode;
  logic             idleTrack;

  assign extMode = (startSel == SEL_EXT);

  always_comb begin
    unique case (startSel)
      SEL_SW:   startEvt = swStart;
      SEL_TMRA: startEvt = tmrAOvf;
      SEL_TMRB: startEvt = tmrBOvf;
      default:  startEvt = extRise;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      donePulse <= 1'b0;
    end else begin
      donePulse <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          cnt <= '0;
          if (startEvt) begin
            state <= (lowPowerMode && !extMode) ? ST_TRACK : ST_CONV;
          end
        end
        ST_TRACK: begin
          if (cnt == LAST_TRACK) begin
            state <= ST_CONV;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_CONV: begin
          if (cnt == LAST_CONV) begin
            state     <= ST_IDLE;
            cnt       <= '0;
            donePulse <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign strobe.clearWork   = (state != ST_CONV);
  assign strobe.decideBit   = (state == ST_CONV) && (cnt < NUM_BITS);
  assign strobe.latchResult = (state == ST_CONV) && (cnt == LAST_CONV);
  assign strobe.bitIdx      = IDX_W'(RES_BITS - 1) - IDX_W'(cnt);

  assign idleTrack    = lowPowerMode ? (extMode && !extLevel) : 1'b1;
  assign busy         = (state != ST_IDLE);
  assign convPhase    = (state == ST_CONV);
  assign trackPhase   = !sleepReq &&
                        ((state == ST_TRACK) || ((state == ST_IDLE) && idleTrack));
  assign lowPowerIdle = !trackPhase && !convPhase;
endmodule

// File: rtl/sar_seq_top.sv
module sar_seq_top
  import sar_seq_pkg::*;
#(
  parameter int RES_BITS = 10,
  parameter int LP_TRACK_CLKS = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          startSel,
  input  logic                lowPowerMode,
  input  logic                sleepReq,
  input  logic                swStart,
  input  logic                tmrAOvf,
  input  logic                tmrBOvf,
  input  logic                extConvPin,
  input  logic                cmpBit,
  output logic [RES_BITS-1:0] trialCode,
  output logic                trackPhase,
  output logic                convPhase,
  output logic                lowPowerIdle,
  output logic                busy,
  output logic                donePulse,
  output logic [RES_BITS-1:0] result
);
  sarStrobe_t strobe;
  logic       extLevel;
  logic       extRise;

  sar_seq_ctrl #(.RES_BITS(RES_BITS), .LP_TRACK_CLKS(LP_TRACK_CLKS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .startSel(startSel), .lowPowerMode(lowPowerMode),
    .sleepReq(sleepReq), .swStart(swStart), .tmrAOvf(tmrAOvf), .tmrBOvf(tmrBOvf),
    .extRise(extRise), .extLevel(extLevel), .strobe(strobe), .busy(busy),
    .trackPhase(trackPhase), .convPhase(convPhase), .lowPowerIdle(lowPowerIdle),
    .donePulse(donePulse)
  );

  sar_seq_dp #(.RES_BITS(RES_BITS), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rst_n(rst_n), .extPinRaw(extConvPin), .cmpBit(cmpBit),
    .strobe(strobe), .extLevel(extLevel), .extRise(extRise),
    .trialCode(trialCode), .result(result)
  );
endmodule

// File: rtl/sar_seq_chk.sv
module sar_seq_chk #(
  parameter int RES_BITS = 10
) (
  input logic                clk,
  input logic                rst_n,
  input logic                sleepReq,
  input logic                trackPhase,
  input logic                convPhase,
  input logic                lowPowerIdle,
  input logic                busy,
  input logic                donePulse,
  input logic [RES_BITS-1:0] result
);
  localparam int CONV_CLKS = RES_BITS + 1;
  logic [7:0] convRun;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         convRun <= '0;
    else if (convPhase) convRun <= (convRun == 8'hFF) ? convRun : convRun + 8'd1;
    else                convRun <= '0;
  end

  assert_one_phase_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot({trackPhase, convPhase, lowPowerIdle}));

  assert_conv_length_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(convPhase) |-> (convRun == 8'(CONV_CLKS)));

  assert_sleep_no_track_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sleepReq |-> !trackPhase);

  assert_done_ends_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    donePulse |-> (!busy && $past(busy)));

  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    donePulse |=> !donePulse);

  assert_result_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !donePulse |-> $stable(result));
endmodule

bind sar_seq_top sar_seq_chk #(.RES_BITS(RES_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .sleepReq(sleepReq), .trackPhase(trackPhase),
  .convPhase(convPhase), .lowPowerIdle(lowPowerIdle), .busy(busy),
  .donePulse(donePulse), .result(result)
);

// File: tb/tb_sar_seq_top.sv
module tb_sar_seq_top;
  localparam int RES = 10;
  localparam int NVEC = 6;
  // {startSel[1:0], lowPowerMode, target[9:0]}
  localparam logic [12:0] VEC [NVEC] = '{
    {2'b00, 1'b0, 10'd0},
    {2'b00, 1'b1, 10'd1023},
    {2'b01, 1'b0, 10'd512},
    {2'b11, 1'b1, 10'd341},
    {2'b01, 1'b1, 10'd682},
    {2'b11, 1'b0, 10'd1}
  };

  logic clk = 0;
  logic rst_n = 0;
  logic [1:0] startSel = 0;
  logic lowPowerMode = 0, sleepReq = 0, swStart = 0, tmrAOvf = 0, tmrBOvf = 0;
  logic extConvPin = 0;
  logic cmpBit;
  logic [RES-1:0] trialCode, result, target = 0;
  logic trackPhase, convPhase, lowPowerIdle, busy, donePulse;

  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  assign cmpBit = (trialCode <= target);

  sar_seq_top dut (
    .clk(clk), .rst_n(rst_n), .startSel(startSel), .lowPowerMode(lowPowerMode),
    .sleepReq(sleepReq), .swStart(swStart), .tmrAOvf(tmrAOvf), .tmrBOvf(tmrBOvf),
    .extConvPin(extConvPin), .cmpBit(cmpBit), .trialCode(trialCode),
    .trackPhase(trackPhase), .convPhase(convPhase), .lowPowerIdle(lowPowerIdle),
    .busy(busy), .donePulse(donePulse), .result(result)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  task automatic pulseSrc(input logic [1:0] sel);
    @(negedge clk);
    case (sel)
      2'b00: swStart = 1;
      2'b01: tmrAOvf = 1;
      2'b11: tmrBOvf = 1;
      default: ;
    endcase
    @(negedge clk);
    swStart = 0; tmrAOvf = 0; tmrBOvf = 0;
  endtask

  // Counts busy cycles from the current negedge until busy drops.
  task automatic runOut(output int nBusy, output int nTrack, output int nConv);
    nBusy = 0; nTrack = 0; nConv = 0;
    while (busy && nBusy < 40) begin
      nBusy++;
      if (trackPhase) nTrack++;
      if (convPhase)  nConv++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: run did not complete");
    finishRun();
  end

  initial begin
    int nB, nT, nC;
    repeat (3) @(negedge clk);
    check("R7 reset busy", busy, 0);
    check("R7 reset done", donePulse, 0);
    check("R8 reset result", result, 0);
    rst_n = 1;
    @(negedge clk);
    check("R2 reset idle tracks", trackPhase, 1);

    // table-driven internal-trigger conversions
    for (int v = 0; v < NVEC; v++) begin
      logic [1:0] sel;
      logic lp;
      sel = VEC[v][12:11];
      lp = VEC[v][10];
      target = VEC[v][9:0];
      startSel = sel; lowPowerMode = lp;
      repeat (2) @(negedge clk);
      if (lp) check("R3 lp idle", lowPowerIdle, 1);
      else    check("R2 continuous idle track", trackPhase, 1);
      pulseSrc(sel);
      check("R7 busy after start", busy, 1);
      runOut(nB, nT, nC);
      check(lp ? "R3 busy length" : "R2 busy length", nB, lp ? 14 : 11);
      check(lp ? "R3 track window" : "R2 no track window", nT, lp ? 3 : 0);
      check("R4 convert clocks", nC, 11);
      check("R7 done with busy fall", donePulse, 1);
      check("R4 R8 result code", result, target);
      @(negedge clk);
      check("R7 done one cycle", donePulse, 0);
    end

    // R5: non-selected sources do nothing
    startSel = 2'b01; lowPowerMode = 0; target = 10'd77;
    @(negedge clk);
    swStart = 1; tmrBOvf = 1;
    @(negedge clk);
    swStart = 0; tmrBOvf = 0;
    extConvPin = 1;
    repeat (4) @(negedge clk);
    check("R5 unselected sources ignored", busy, 0);
    check("R5 result unchanged", result, 10'd1);
    extConvPin = 0;
    repeat (3) @(negedge clk);

    // R9: starts during busy ignored
    startSel = 2'b00; target = 10'd600;
    pulseSrc(2'b00);
    repeat (4) @(negedge clk);
    swStart = 1;
    @(negedge clk);
    swStart = 0;
    runOut(nB, nT, nC);
    check("R9 busy length unchanged", nB, 11 - 5);
    check("R9 result", result, 10'd600);
    repeat (3) @(negedge clk);
    check("R9 no restart", busy, 0);

    // R6: sleep forces tracking off
    sleepReq = 1;
    @(negedge clk);
    check("R6 sleep no track", trackPhase, 0);
    check("R6 sleep lp idle", lowPowerIdle, 1);
    sleepReq = 0;
    @(negedge clk);
    check("R6 track back", trackPhase, 1);

    // R10: external pin, low-power mode
    startSel = 2'b10; lowPowerMode = 1; target = 10'd999; extConvPin = 0;
    repeat (3) @(negedge clk);
    check("R10 tracks while pin low", trackPhase, 1);
    extConvPin = 1;
    repeat (2) @(negedge clk);
    check("R10 not busy after two edges", busy, 0);
    check("R10 stops tracking on high pin", lowPowerIdle, 1);
    @(negedge clk);
    check("R10 busy after third edge", busy, 1);
    runOut(nB, nT, nC);
    check("R10 ext busy length", nB, 11);
    check("R4 ext result", result, 10'd999);
    repeat (3) @(negedge clk);
    check("R10 no restart on held pin", busy, 0);
    check("R10 held high no track", trackPhase, 0);
    extConvPin = 0;
    repeat (3) @(negedge clk);
    check("R10 track after pin low", trackPhase, 1);

    // R1: phase exclusivity sampled in current state
    check("R1 one phase", 32'(trackPhase) + 32'(convPhase) + 32'(lowPowerIdle), 1);

    finishRun();
  end
endmodule